// File: doc/BRIEF.md
# Calendar Clock Counter Chain

This block keeps time of day and calendar date in a ladder of eight byte-wide counters. The lowest counts hundredths of a second and the highest counts a two-digit year. The hundredths counter advances on a tick. A prescaler makes that tick by counting clock cycles in which the oscillator enable input is high. The divide ratio is one of four settings held in a command byte. The same byte selects whether hours are kept in 24-hour or in 12-hour form with a PM flag.

Software reaches the counters through a byte-wide register port, and each counter has its own address. A read of the hundredths counter returns its live value. In the same cycle it freezes a copy of all eight counters. Reads of the other counters then return that frozen copy, so a time read byte by byte stays coherent even if the counters roll over in the middle of the read. While the power-fail input is high, the port ignores every access, and timekeeping carries on.

Top module: `calClockTop`

## Requirements
- R1: After reset, every counter reads 0 except month and date, which read 1, and the command byte reads 0 (24-hour mode, ratio setting 0).
- R2: Hundredths advances once per BASE_DIV << cmd[1:0] clock cycles with the oscillator enable high; cycles with it low do not count.
- R3: Hundredths wraps 99 to 0, seconds wraps 59 to 0 and minutes wraps 59 to 0. Each wrap carries one into the next counter: hundredths into seconds, seconds into minutes, minutes into hours.
- R4: With cmd[2]=0, hours run 0 to 23, and the wrap from 23 to 0 advances the day.
- R5: With cmd[2]=1, hours bits 4:0 run 1 to 12 and bit 7 is the PM flag. Going from 11 to 12 toggles the flag. The day advances only when 11 with PM set becomes 12 with PM clear. 12 becomes 1 with the flag kept.
- R6: On a day advance, day-of-week wraps 6 to 0. Date wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 29 for month 2 when year mod 4 is 0, otherwise 28 for month 2, and 31 for the other months. Month wraps 12 to 1 and carries into year, which wraps 99 to 0.
- R7: The counter addresses are 0 hundredths, 1 hours, 2 minutes, 3 seconds, 4 month, 5 date, 6 year and 7 day-of-week. A read of address 0 returns the live hundredths and captures all eight counters in that cycle. A read of addresses 1 to 7 returns the captured value.
- R8: The captured copy does not change until the next read of address 0, whatever the live counters do.
- R9: While pwrFail is high, reads and writes have no effect: busRdData holds, no counter or command byte is loaded, no capture is taken. Counting continues.
- R10: A write to addresses 0 to 7 loads that counter. If a tick falls in the same cycle, the written counter takes the written value and the other counters advance. A write to address 0 also clears the prescaler and drops any tick in that cycle.
- R11: The command byte is at address 0x11 and uses bits 2:0. Read data appears on busRdData the cycle after busRdEn. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | Oscillator enable; each high cycle is one prescaler count |
| pwrFail | input | 1 | Power-fail; blocks all bus access while high |
| busAddr | input | 5 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |

## Verification
Two functions can fall in the same cycle. A bus write and a prescaler tick can meet, and so can a capturing read and a tick. The bench provokes both by holding the oscillator enable high for exactly one cycle fewer than the divide ratio, then raising the write or read strobe together with the last enable cycle. A per-cycle behavioural model judges each case: the written counter must win while its neighbours advance, a hundredths write must swallow the tick, and a capture must hold the values from before the edge.

// File: rtl/calClockPkg.sv
package calClockPkg;
  localparam int NCNT = 8;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam logic [AW-1:0] CMD_ADDR = 5'h11;

  typedef enum logic [2:0] {
    IDX_HUND  = 3'd0,
    IDX_HOUR  = 3'd1,
    IDX_MIN   = 3'd2,
    IDX_SEC   = 3'd3,
    IDX_MONTH = 3'd4,
    IDX_DATE  = 3'd5,
    IDX_YEAR  = 3'd6,
    IDX_DOW   = 3'd7
  } cntIdx_e;

  typedef struct packed {
    logic          tick;
    logic          wrEn;
    logic [2:0]    wrIdx;
    logic [DW-1:0] wrData;
    logic          snap;
    logic          mode12;
  } strobes_t;

  function automatic logic [DW-1:0] monthLen(input logic [DW-1:0] month,
                                             input logic [DW-1:0] year);
    logic [DW-1:0] len;
    if (month == 8'd2)
      len = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
    else if (month == 8'd4 || month == 8'd6 || month == 8'd9 || month == 8'd11)
      len = 8'd30;
    else
      len = 8'd31;
    return len;
  endfunction

  function automatic logic [DW-1:0] resetVal(input int idx);
    return (idx == int'(IDX_MONTH) || idx == int'(IDX_DATE)) ? 8'd1 : 8'd0;
  endfunction
endpackage

// File: rtl/calClockCtrl.sv
module calClockCtrl
  import calClockPkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     oscEn,
  input  logic                     pwrFail,
  input  logic [AW-1:0]            busAddr,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [DW-1:0]            busWrData,
  input  logic [DW-1:0]            liveHund,
  input  logic [NCNT-1:0][DW-1:0]  snapVals,
  output strobes_t                 st,
  output logic [DW-1:0]            busRdData
);
  localparam int MAXDIV = BASE_DIV * 8;
  localparam int PW     = $clog2(MAXDIV) + 1;

  logic [2:0]    cmdQ;
  logic [PW-1:0] preCnt;
  logic [PW-1:0] divisor;
  logic          access, cntSel, wrCnt, hundWr, tick;

  assign divisor = PW'(BASE_DIV) << cmdQ[1:0];
  assign access  = !pwrFail;
  assign cntSel  = busAddr < AW'(NCNT);
  assign wrCnt   = busWrEn && access && cntSel;
  assign hundWr  = wrCnt && (busAddr == AW'(0));
  assign tick    = oscEn && (preCnt >= divisor - PW'(1)) && !hundWr;

  always_comb begin
    st.tick   = tick;
    st.wrEn   = wrCnt;
    st.wrIdx  = busAddr[2:0];
    st.wrData = busWrData;
    st.snap   = busRdEn && access && (busAddr == AW'(0));
    st.mode12 = cmdQ[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (hundWr) begin
      preCnt <= '0;
    end else if (oscEn) begin
      preCnt <= tick ? '0 : preCnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (busWrEn && access && busAddr == CMD_ADDR) begin
      cmdQ <= busWrData[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (busRdEn && access) begin
      if (cntSel)
        busRdData <= (busAddr == AW'(0)) ? liveHund : snapVals[busAddr[2:0]];
      else if (busAddr == CMD_ADDR)
        busRdData <= {5'b0, cmdQ};
      else
        busRdData <= '0;
    end
  end

  // R9
  pf_rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> $stable(busRdData));

  // R2
  presc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt < PW'(MAXDIV));

  // R10
  hund_wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !pwrFail && busAddr == AW'(0)) |=> (preCnt == '0));
endmodule

// File: rtl/calClockDatapath.sv
module calClockDatapath
  import calClockPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 st,
  output logic [NCNT-1:0][DW-1:0]  liveVals,
  output logic [NCNT-1:0][DW-1:0]  snapVals
);
  logic [NCNT-1:0][DW-1:0] adv;
  logic                    c;
  logic [4:0]              hr;
  logic                    pm;

  always_comb begin
    adv = liveVals;
    c   = 1'b0;
    hr  = liveVals[IDX_HOUR][4:0];
    pm  = liveVals[IDX_HOUR][7];
    if (st.tick) begin
      c = 1'b1;
      if (liveVals[IDX_HUND] >= 8'd99) adv[IDX_HUND] = '0;
      else begin adv[IDX_HUND] = liveVals[IDX_HUND] + 8'd1; c = 1'b0; end
      if (c) begin
        if (liveVals[IDX_SEC] >= 8'd59) adv[IDX_SEC] = '0;
        else begin adv[IDX_SEC] = liveVals[IDX_SEC] + 8'd1; c = 1'b0; end
      end
      if (c) begin
        if (liveVals[IDX_MIN] >= 8'd59) adv[IDX_MIN] = '0;
        else begin adv[IDX_MIN] = liveVals[IDX_MIN] + 8'd1; c = 1'b0; end
      end
      if (c) begin
        if (st.mode12) begin
          if (hr == 5'd11) begin
            adv[IDX_HOUR] = {~pm, 2'b00, 5'd12};
            c = pm;
          end else if (hr >= 5'd12) begin
            adv[IDX_HOUR] = {pm, 2'b00, 5'd1};
            c = 1'b0;
          end else begin
            adv[IDX_HOUR] = {pm, 2'b00, hr + 5'd1};
            c = 1'b0;
          end
        end else begin
          if (liveVals[IDX_HOUR] >= 8'd23) adv[IDX_HOUR] = '0;
          else begin adv[IDX_HOUR] = liveVals[IDX_HOUR] + 8'd1; c = 1'b0; end
        end
      end
      if (c) begin
        adv[IDX_DOW] = (liveVals[IDX_DOW] >= 8'd6) ? 8'd0 : liveVals[IDX_DOW] + 8'd1;
        if (liveVals[IDX_DATE] >= monthLen(liveVals[IDX_MONTH], liveVals[IDX_YEAR]))
          adv[IDX_DATE] = 8'd1;
        else begin adv[IDX_DATE] = liveVals[IDX_DATE] + 8'd1; c = 1'b0; end
      end
      if (c) begin
        if (liveVals[IDX_MONTH] >= 8'd12) adv[IDX_MONTH] = 8'd1;
        else begin adv[IDX_MONTH] = liveVals[IDX_MONTH] + 8'd1; c = 1'b0; end
      end
      if (c) begin
        adv[IDX_YEAR] = (liveVals[IDX_YEAR] >= 8'd99) ? 8'd0 : liveVals[IDX_YEAR] + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCNT; i++) begin
      if (!rstN)
        liveVals[i] <= resetVal(i);
      else if (st.wrEn && st.wrIdx == 3'(i))
        liveVals[i] <= st.wrData;
      else
        liveVals[i] <= adv[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      snapVals <= '0;
    else if (st.snap)
      snapVals <= liveVals;
  end

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.snap |=> (snapVals == $past(liveVals)));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.snap |=> $stable(snapVals));

  // R3
  hund_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && !st.wrEn) |=> (liveVals[IDX_HUND] != $past(liveVals[IDX_HUND])));
endmodule

// File: rtl/calClockTop.sv
module calClockTop
  import calClockPkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscEn,
  input  logic          pwrFail,
  input  logic [4:0]    busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [7:0]    busWrData,
  output logic [7:0]    busRdData
);
  strobes_t                st;
  logic [NCNT-1:0][DW-1:0] liveVals;
  logic [NCNT-1:0][DW-1:0] snapVals;

  calClockCtrl #(.BASE_DIV(BASE_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .pwrFail(pwrFail),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .liveHund(liveVals[IDX_HUND]),
    .snapVals(snapVals), .st(st), .busRdData(busRdData)
  );

  calClockDatapath dp (
    .clk(clk), .rstN(rstN), .st(st),
    .liveVals(liveVals), .snapVals(snapVals)
  );
endmodule

// File: tb/calClockTop_test.sv
module calClockTop_test;
  localparam int PERIOD   = 10;
  localparam int BASE_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscEn = 1'b0;
  logic       pwrFail = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int errors = 0;
  int checks = 0;

  calClockTop #(.BASE_DIV(BASE_DIV)) uut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .pwrFail(pwrFail),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m[8], ms[8], nv[8];
  int mcmd, mpre, mrd, div, hh, pmf;
  bit tk, acc, hwr, c;

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m = '{0, 0, 0, 0, 1, 1, 0, 0};
      ms = '{0, 0, 0, 0, 0, 0, 0, 0};
      mcmd = 0; mpre = 0; mrd = 0;
    end else begin
      acc = !pwrFail;
      hwr = acc && busWrEn && busAddr == 0;
      div = BASE_DIV << (mcmd & 3);
      tk  = oscEn && (mpre >= div - 1) && !hwr;
      nv = m;
      if (tk) begin
        c = 1;
        if (m[0] >= 99) nv[0] = 0; else begin nv[0] = m[0] + 1; c = 0; end
        if (c) begin if (m[3] >= 59) nv[3] = 0; else begin nv[3] = m[3] + 1; c = 0; end end
        if (c) begin if (m[2] >= 59) nv[2] = 0; else begin nv[2] = m[2] + 1; c = 0; end end
        if (c) begin
          if (mcmd & 4) begin
            hh = m[1] & 31; pmf = m[1] & 128;
            if (hh == 11) begin nv[1] = 12 | (pmf ^ 128); c = (pmf != 0); end
            else if (hh >= 12) begin nv[1] = 1 | pmf; c = 0; end
            else begin nv[1] = (hh + 1) | pmf; c = 0; end
          end else begin
            if (m[1] >= 23) nv[1] = 0; else begin nv[1] = m[1] + 1; c = 0; end
          end
        end
        if (c) begin
          nv[7] = (m[7] >= 6) ? 0 : m[7] + 1;
          if (m[5] >= mlen(m[4], m[6])) nv[5] = 1; else begin nv[5] = m[5] + 1; c = 0; end
        end
        if (c) begin if (m[4] >= 12) nv[4] = 1; else begin nv[4] = m[4] + 1; c = 0; end end
        if (c) nv[6] = (m[6] >= 99) ? 0 : m[6] + 1;
      end
      if (acc && busRdEn) begin
        if (busAddr == 0) begin mrd = m[0]; ms = m; end
        else if (busAddr < 8) mrd = ms[busAddr];
        else if (busAddr == 5'h11) mrd = mcmd;
        else mrd = 0;
      end
      if (hwr) mpre = 0;
      else if (oscEn) mpre = tk ? 0 : mpre + 1;
      if (acc && busWrEn) begin
        if (busAddr < 8) nv[busAddr] = busWrData;
        else if (busAddr == 5'h11) mcmd = busWrData & 7;
      end
      m = nv;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (int'(busRdData) != mrd) begin
        errors++;
        $display("FAIL R11 cycle compare: busRdData actual=%0d expected=%0d", busRdData, mrd);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    busAddr = 5'(a); busWrData = 8'(d); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    busAddr = 5'(a); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    v = int'(busRdData);
  endtask

  task automatic runOsc(input int n);
    oscEn = 1'b1;
    repeat (n) @(negedge clk);
    oscEn = 1'b0;
  endtask

  // set up 23:59:59.99 style state then one tick (ratio setting 0)
  task automatic rollDay(input int hour);
    wr(1, hour); wr(2, 59); wr(3, 59); wr(0, 99);
    runOsc(BASE_DIV);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h11, v); chk("R1 cmd after reset", v, 0);
    rd(0, v);     chk("R1 hundredths after reset", v, 0);
    rd(4, v);     chk("R1 month after reset", v, 1);
    rd(5, v);     chk("R1 date after reset", v, 1);
    rd(1, v);     chk("R1 hours after reset", v, 0);

    // R11 unmapped address
    rd(9, v);     chk("R11 unmapped reads zero", v, 0);

    // R2 prescaler ratios
    wr(0, 0); runOsc(BASE_DIV * 5);
    rd(0, v); chk("R2 ratio0 five ticks", v, 5);
    wr(5'h11, 2); rd(5'h11, v); chk("R11 cmd readback", v, 2);
    wr(0, 0); runOsc(BASE_DIV * 8);
    rd(0, v); chk("R2 ratio2 two ticks", v, 2);
    wr(5'h11, 0);

    // R3 lower chain
    wr(1, 5); rollDay(5);
    rd(0, v); chk("R3 hundredths wrap", v, 0);
    rd(3, v); chk("R3 seconds wrap", v, 0);
    rd(2, v); chk("R3 minutes wrap", v, 0);
    rd(1, v); chk("R3 hours carry-in", v, 6);

    // R4 24-hour day rollover
    wr(7, 6); wr(5, 10); wr(4, 3); rollDay(23);
    rd(0, v); rd(1, v); chk("R4 hours 23 to 0", v, 0);
    rd(7, v); chk("R6 dow 6 to 0", v, 0);
    rd(5, v); chk("R4 date advanced", v, 11);

    // R6 month lengths and leap year
    wr(4, 2); wr(5, 28); wr(6, 4); rollDay(23);
    rd(0, v); rd(5, v); chk("R6 leap feb 29", v, 29);
    rd(4, v); chk("R6 leap month kept", v, 2);
    rollDay(23);
    rd(0, v); rd(5, v); chk("R6 leap feb end", v, 1);
    rd(4, v); chk("R6 march after leap feb", v, 3);
    wr(4, 2); wr(5, 28); wr(6, 5); rollDay(23);
    rd(0, v); rd(5, v); chk("R6 common feb end", v, 1);
    wr(4, 4); wr(5, 30); rollDay(23);
    rd(0, v); rd(4, v); chk("R6 30-day month end", v, 5);
    wr(4, 12); wr(5, 31); wr(6, 99); rollDay(23);
    rd(0, v); rd(4, v); chk("R6 month 12 to 1", v, 1);
    rd(6, v); chk("R6 year 99 to 0", v, 0);
    rd(5, v); chk("R6 date 31 to 1", v, 1);

    // R5 12-hour mode
    wr(5'h11, 4); wr(5, 10); wr(4, 6);
    rollDay(11);
    rd(0, v); rd(1, v); chk("R5 11AM to 12PM", v, 8'h8C);
    rd(5, v); chk("R5 no day at noon", v, 10);
    rollDay(8'h8B);
    rd(0, v); rd(1, v); chk("R5 11PM to 12AM", v, 8'h0C);
    rd(5, v); chk("R5 day at midnight", v, 11);
    rollDay(12);
    rd(0, v); rd(1, v); chk("R5 12 to 1", v, 1);
    wr(5'h11, 0);

    // R7 / R8 snapshot capture and hold
    wr(3, 10); wr(0, 50);
    rd(0, v); chk("R7 live hundredths", v, 50);
    wr(3, 25);
    rd(3, v); chk("R8 snapshot held", v, 10);
    rd(0, v); rd(3, v); chk("R7 new capture", v, 25);

    // R9 power fail
    wr(3, 20); wr(0, 10);
    rd(0, v); rd(3, v); chk("R9 setup", v, 20);
    pwrFail = 1'b1;
    rd(5'h11, v); chk("R9 read ignored", v, 20);
    wr(3, 33); wr(5'h11, 4);
    runOsc(BASE_DIV);
    pwrFail = 1'b0;
    rd(0, v); chk("R9 counting continued", v, 11);
    rd(3, v); chk("R9 write ignored", v, 20);
    rd(5'h11, v); chk("R9 cmd write ignored", v, 0);

    // R10 write meeting a tick
    wr(0, 99); wr(3, 5);
    runOsc(BASE_DIV - 1);
    oscEn = 1'b1; busAddr = 5'd3; busWrData = 8'd40; busWrEn = 1'b1;
    @(negedge clk);
    oscEn = 1'b0; busWrEn = 1'b0;
    rd(0, v); chk("R10 hundredths advanced beside write", v, 0);
    rd(3, v); chk("R10 written counter wins", v, 40);
    wr(0, 20);
    runOsc(BASE_DIV - 1);
    oscEn = 1'b1; busAddr = 5'd0; busWrData = 8'd7; busWrEn = 1'b1;
    @(negedge clk);
    oscEn = 1'b0; busWrEn = 1'b0;
    runOsc(BASE_DIV - 1);
    rd(0, v); chk("R10 hundredths write drops tick", v, 7);
    runOsc(1);
    rd(0, v); chk("R10 prescaler restarted", v, 8);

    // R7 capture in the same cycle as a tick
    wr(0, 30);
    runOsc(BASE_DIV - 1);
    oscEn = 1'b1; busAddr = 5'd0; busRdEn = 1'b1;
    @(negedge clk);
    oscEn = 1'b0; busRdEn = 1'b0;
    chk("R7 capture sees pre-tick value", int'(busRdData), 30);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule